// File: doc/BRIEF.md
# DQ lane delay-lock classifier

This block evaluates the outcome of delay-line sweeps for one byte lane of a memory data interface. An external sweep engine produces one result word per data bit. The classifier consumes those words and decides whether the lane has locked a common delay shift. If it has not, it decides whether the lane needs an extended search, needs a shifted search, or has failed outright.

Software-independent control logic issues a start strobe together with the direction (receive or transmit) for each sweep. It then streams up to eight result words over a valid/ready handshake. The lane state persists from sweep to sweep, so repeated sweeps walk the lane down a ladder: primary, then extended, then shifted. A lane that falls off the bottom of the ladder is marked failed.

Each passing bit is converted to its first failing tap. The lane's shift is the largest of those taps in receive mode and the smallest in transmit mode. The block raises a one-cycle done pulse when it has finished with a sweep.

Top module: `dql_lane_classifier`

## Requirements
- R1: After a synchronous active-high reset the outputs are as follows: lane state is primary (code 3), lock is 1, shift is 0, done is 0 and ready is 0.
- R2: The block accepts a start only while it is idle. When it does, it captures the mode (0 = receive, 1 = transmit), clears the shift and the running maximum, and sets the running minimum to 31 (receive) or 63 (transmit). In a lane that has not failed, ready is then 1 from the next cycle on. A start or mode change while ready is 1 has no effect on the sweep in progress.
- R3: Each result word is decoded as follows. Bit 25 is the completion flag. The value is bits [4:0] in receive mode and bits [5:0] in transmit mode. A passing bit's tap is value+1 in receive mode. In transmit mode it is value-1, saturating at 0.
- R4: In the primary state (3), a clear completion flag moves the lane to fail (1). A value of 31 (receive) or 0 (transmit) moves it to extended (4). Either case clears lock and ends the sweep at that word.
- R5: The shift output is the running maximum of the sweep's taps in receive mode and the running minimum in transmit mode. It is updated on every passing word.
- R6: In the extended state (4), a clear flag or a no-window value moves the lane to shifted (2), clears lock and ends the sweep. Each passing word sets lock to 1.
- R7: In the shifted state (2), the no-window value is not tested. A clear flag moves the lane to fail (1) and ends the sweep. Lock becomes 1 at the end only if all eight words carried the flag.
- R8: Done is a one-cycle pulse. It appears in the cycle after the eighth accepted word or after a word that ends the sweep early. Ready is 0 while done is 1, and words presented while ready is 0 are not consumed.
- R9: A start in the fail state (1) produces done in the next cycle, and ready stays 0. Only reset leaves the fail state.
- R10: The lane state changes only along these steps: 3 to 4, 3 to 1, 4 to 2 and 2 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin evaluating one sweep |
| mode_tx | input | 1 | 0 = receive, 1 = transmit; captured at start |
| res_valid | input | 1 | Result word valid |
| res_word | input | 32 | Per-bit result word from the sweep engine |
| res_ready | output | 1 | Block is accepting result words |
| lane_state | output | 3 | 4 extended, 3 primary, 2 shifted, 1 fail |
| lane_lock | output | 1 | Lane holds a common delay shift |
| shift_val | output | 6 | Chosen delay shift |
| done | output | 1 | One-cycle pulse at the end of a sweep |

## Verification
Two things can happen on the same word: the early end of a sweep because of a no-window or failed word, and the normal end after the eighth bit. The bench provokes this by placing a no-window value in the eighth word of an extended sweep. It judges the result by three observations: the lane must step to shifted, done must fire exactly once, and a further word presented afterwards must not be consumed. The per-clock reference model also covers starts and mode flips injected into gaps in the valid stream while a sweep is running.

// File: rtl/dql_pkg.sv
package dql_pkg;
    typedef enum logic [2:0] {
        LS_PASS     = 3'd0,
        LS_FAIL     = 3'd1,
        LS_SHIFTED  = 3'd2,
        LS_PRIMARY  = 3'd3,
        LS_EXTENDED = 3'd4
    } lane_state_e;
endpackage

// File: rtl/dql_word_decode.sv
module dql_word_decode #(
    parameter int WORD_W   = 32,
    parameter int FLAG_POS = 25,
    parameter int RX_VW    = 5,
    parameter int TX_VW    = 6,
    parameter int TAP_W    = 6
) (
    input  logic [WORD_W-1:0] word,
    input  logic              mode_tx,
    output logic              flag_ok,
    output logic              no_window,
    output logic [TAP_W-1:0]  tap
);
    localparam logic [RX_VW-1:0] RX_FULL = {RX_VW{1'b1}};

    logic [RX_VW-1:0] rx_val;
    logic [TX_VW-1:0] tx_val;
    logic [TAP_W-1:0] rx_ext;
    logic [TAP_W-1:0] tx_ext;
    logic             unused_word;

    assign rx_val      = word[RX_VW-1:0];
    assign tx_val      = word[TX_VW-1:0];
    assign rx_ext      = TAP_W'(rx_val);
    assign tx_ext      = TAP_W'(tx_val);
    assign flag_ok     = word[FLAG_POS];
    assign unused_word = ^word;

    always_comb begin
        if (mode_tx) begin
            no_window = (tx_val == '0);
            tap       = (tx_val == '0) ? '0 : tx_ext - TAP_W'(1);
        end else begin
            no_window = (rx_val == RX_FULL);
            tap       = rx_ext + TAP_W'(1);
        end
    end
endmodule

// File: rtl/dql_minmax.sv
module dql_minmax #(
    parameter int TAP_W = 6
) (
    input  logic             mode_tx,
    input  logic [TAP_W-1:0] cur_min,
    input  logic [TAP_W-1:0] cur_max,
    input  logic [TAP_W-1:0] tap,
    output logic [TAP_W-1:0] nxt_min,
    output logic [TAP_W-1:0] nxt_max,
    output logic [TAP_W-1:0] nxt_shift
);
    always_comb begin
        nxt_max   = (tap > cur_max) ? tap : cur_max;
        nxt_min   = (tap < cur_min) ? tap : cur_min;
        nxt_shift = mode_tx ? nxt_min : nxt_max;
    end
endmodule

// File: rtl/dql_ctrl.sv
module dql_ctrl
    import dql_pkg::*;
#(
    parameter int NBITS = 8,
    parameter int RX_VW = 5,
    parameter int TX_VW = 6,
    parameter int TAP_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             mode_tx,
    input  logic             res_valid,
    input  logic             flag_ok,
    input  logic             no_window,
    input  logic [TAP_W-1:0] nxt_min,
    input  logic [TAP_W-1:0] nxt_max,
    input  logic [TAP_W-1:0] nxt_shift,
    output logic             cur_mode,
    output logic [TAP_W-1:0] run_min,
    output logic [TAP_W-1:0] run_max,
    output logic             res_ready,
    output lane_state_e      lane_state,
    output logic             lane_lock,
    output logic [TAP_W-1:0] shift_val,
    output logic             done
);
    localparam int CNT_W = (NBITS > 1) ? $clog2(NBITS) : 1;
    localparam logic [TAP_W-1:0] RX_INIT = TAP_W'((1 << RX_VW) - 1);
    localparam logic [TAP_W-1:0] TX_INIT = TAP_W'((1 << TX_VW) - 1);
    localparam logic [TAP_W-1:0] RX_CAP  = RX_INIT + TAP_W'(1);
    localparam logic [CNT_W-1:0] LAST_IX = CNT_W'(NBITS - 1);
    localparam logic [CNT_W:0]   ALL_OK  = (CNT_W+1)'(NBITS);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] idx;
        lane_state_e      st;
        logic             lock;
        logic [TAP_W-1:0] mn;
        logic [TAP_W-1:0] mx;
        logic [TAP_W-1:0] sh;
        logic [CNT_W:0]   npass;
        logic             mode;
        logic             done;
    } ctrl_t;

    ctrl_t q, d;
    logic  abort_w;
    logic  good_w;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        abort_w = 1'b0;
        good_w  = 1'b0;
        if (!q.busy) begin
            if (start) begin
                d.mode  = mode_tx;
                d.mn    = mode_tx ? TX_INIT : RX_INIT;
                d.mx    = '0;
                d.sh    = '0;
                d.npass = '0;
                d.idx   = '0;
                if (q.st == LS_FAIL) d.done = 1'b1;
                else                 d.busy = 1'b1;
            end
        end else if (res_valid) begin
            case (q.st)
                LS_PRIMARY: begin
                    if (!flag_ok) begin
                        d.st = LS_FAIL;     d.lock = 1'b0; abort_w = 1'b1;
                    end else if (no_window) begin
                        d.st = LS_EXTENDED; d.lock = 1'b0; abort_w = 1'b1;
                    end else begin
                        good_w = 1'b1;
                    end
                end
                LS_EXTENDED: begin
                    if (!flag_ok || no_window) begin
                        d.st = LS_SHIFTED;  d.lock = 1'b0; abort_w = 1'b1;
                    end else begin
                        d.lock = 1'b1;      good_w = 1'b1;
                    end
                end
                LS_SHIFTED: begin
                    if (!flag_ok) begin
                        d.st = LS_FAIL;     abort_w = 1'b1;
                    end else begin
                        d.npass = q.npass + 1'b1;
                        good_w  = 1'b1;
                    end
                end
                default: abort_w = 1'b1;
            endcase
            if (good_w) begin
                d.mn = nxt_min;
                d.mx = nxt_max;
                d.sh = nxt_shift;
            end
            if (abort_w || (q.idx == LAST_IX)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
                if (!abort_w && (q.st == LS_SHIFTED))
                    d.lock = (d.npass == ALL_OK);
            end else begin
                d.idx = q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= '0;
            q.st   <= LS_PRIMARY;
            q.lock <= 1'b1;
            q.mn   <= TX_INIT;
        end else begin
            q <= d;
        end
    end

    assign cur_mode   = q.mode;
    assign run_min    = q.mn;
    assign run_max    = q.mx;
    assign res_ready  = q.busy;
    assign lane_state = q.st;
    assign lane_lock  = q.lock;
    assign shift_val  = q.sh;
    assign done       = q.done;

    AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        done |-> !res_ready); // R8
    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (q.st == LS_FAIL) |=> (q.st == LS_FAIL)); // R9
    AST_LEGAL_STEP: assert property (@(posedge clk) disable iff (rst)
        (q.st != $past(q.st)) |->
            (($past(q.st) == LS_PRIMARY && (q.st == LS_EXTENDED || q.st == LS_FAIL)) ||
             ($past(q.st) == LS_EXTENDED && q.st == LS_SHIFTED) ||
             ($past(q.st) == LS_SHIFTED && q.st == LS_FAIL))); // R10
    AST_EXT_ENTRY_UNLOCK: assert property (@(posedge clk) disable iff (rst)
        (q.st == LS_EXTENDED && $past(q.st) == LS_PRIMARY) |-> !q.lock); // R4
    AST_SHIFT_HOLDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(q.busy && res_valid) && !$past(start)) |-> $stable(q.sh)); // R5
    AST_RX_TAP_CAP: assert property (@(posedge clk) disable iff (rst)
        !q.mode |-> (q.sh <= RX_CAP)); // R3
endmodule

// File: rtl/dql_lane_classifier.sv
module dql_lane_classifier
    import dql_pkg::*;
#(
    parameter int NBITS    = 8,
    parameter int WORD_W   = 32,
    parameter int FLAG_POS = 25,
    parameter int RX_VW    = 5,
    parameter int TX_VW    = 6,
    localparam int TAP_W   = (TX_VW > RX_VW + 1) ? TX_VW : RX_VW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              mode_tx,
    input  logic              res_valid,
    input  logic [WORD_W-1:0] res_word,
    output logic              res_ready,
    output logic [2:0]        lane_state,
    output logic              lane_lock,
    output logic [TAP_W-1:0]  shift_val,
    output logic              done
);
    logic             cur_mode;
    logic             flag_ok;
    logic             no_window;
    logic [TAP_W-1:0] tap;
    logic [TAP_W-1:0] run_min, run_max;
    logic [TAP_W-1:0] nxt_min, nxt_max, nxt_shift;
    lane_state_e      st;

    dql_word_decode #(
        .WORD_W(WORD_W), .FLAG_POS(FLAG_POS),
        .RX_VW(RX_VW), .TX_VW(TX_VW), .TAP_W(TAP_W)
    ) u_decode (
        .word(res_word), .mode_tx(cur_mode),
        .flag_ok(flag_ok), .no_window(no_window), .tap(tap)
    );

    dql_minmax #(.TAP_W(TAP_W)) u_minmax (
        .mode_tx(cur_mode), .cur_min(run_min), .cur_max(run_max), .tap(tap),
        .nxt_min(nxt_min), .nxt_max(nxt_max), .nxt_shift(nxt_shift)
    );

    dql_ctrl #(
        .NBITS(NBITS), .RX_VW(RX_VW), .TX_VW(TX_VW), .TAP_W(TAP_W)
    ) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .mode_tx(mode_tx),
        .res_valid(res_valid), .flag_ok(flag_ok), .no_window(no_window),
        .nxt_min(nxt_min), .nxt_max(nxt_max), .nxt_shift(nxt_shift),
        .cur_mode(cur_mode), .run_min(run_min), .run_max(run_max),
        .res_ready(res_ready), .lane_state(st), .lane_lock(lane_lock),
        .shift_val(shift_val), .done(done)
    );

    assign lane_state = st;
endmodule

// File: tb/dql_lane_classifier_bench.sv
module dql_lane_classifier_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        mode_tx = 1'b0;
    logic        res_valid = 1'b0;
    logic [31:0] res_word = '0;
    logic        res_ready;
    logic [2:0]  lane_state;
    logic        lane_lock;
    logic [5:0]  shift_val;
    logic        done;

    int nvec = 0;
    int nfail = 0;
    string cur_tag = "R1";

    // reference model state
    int m_st, m_lock, m_mn, m_mx, m_sh, m_busy, m_idx, m_mode, m_pc, m_done;

    always #2.5 clk = ~clk;

    dql_lane_classifier u_dql_lane_classifier (
        .clk(clk), .rst(rst), .start(start), .mode_tx(mode_tx),
        .res_valid(res_valid), .res_word(res_word), .res_ready(res_ready),
        .lane_state(lane_state), .lane_lock(lane_lock),
        .shift_val(shift_val), .done(done)
    );

    task automatic chk(input string what, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s act=%0d exp=%0d", cur_tag, what, act, exp);
        end
    endtask

    task automatic model_step();
        int v, tap, abort, good;
        m_done = 0;
        if (rst) begin
            m_st = 3; m_lock = 1; m_mn = 63; m_mx = 0; m_sh = 0;
            m_busy = 0; m_idx = 0; m_mode = 0; m_pc = 0;
        end else if (!m_busy) begin
            if (start) begin
                m_mode = mode_tx; m_mn = mode_tx ? 63 : 31; m_mx = 0; m_sh = 0;
                m_pc = 0; m_idx = 0;
                if (m_st == 1) m_done = 1; else m_busy = 1;
            end
        end else if (res_valid) begin
            v = m_mode ? int'(res_word[5:0]) : int'(res_word[4:0]);
            tap = m_mode ? ((v == 0) ? 0 : v - 1) : v + 1;
            abort = 0; good = 0;
            if (m_st == 3) begin
                if (!res_word[25]) begin m_st = 1; m_lock = 0; abort = 1; end
                else if (m_mode ? (v == 0) : (v == 31)) begin m_st = 4; m_lock = 0; abort = 1; end
                else good = 1;
            end else if (m_st == 4) begin
                if (!res_word[25] || (m_mode ? (v == 0) : (v == 31))) begin
                    m_st = 2; m_lock = 0; abort = 1;
                end else begin m_lock = 1; good = 1; end
            end else begin
                if (!res_word[25]) begin m_st = 1; abort = 1; end
                else begin m_pc++; good = 1; end
            end
            if (good) begin
                if (tap > m_mx) m_mx = tap;
                if (tap < m_mn) m_mn = tap;
                m_sh = m_mode ? m_mn : m_mx;
            end
            if (abort || m_idx == 7) begin
                m_busy = 0; m_done = 1;
                if (!abort && m_st == 2) m_lock = (m_pc == 8) ? 1 : 0;
            end else m_idx++;
        end
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk("lane_state", int'(lane_state), m_st);
        chk("lane_lock", int'(lane_lock), m_lock);
        chk("shift_val", int'(shift_val), m_sh);
        chk("done", int'(done), m_done);
        chk("res_ready", int'(res_ready), m_busy);
    endtask

    function automatic logic [31:0] mk(input int f, input int v);
        return (32'(f) << 25) | 32'(v);
    endfunction

    task automatic do_reset();
        rst = 1'b1; start = 0; res_valid = 0;
        tick(); tick();
        rst = 1'b0;
        tick();
    endtask

    // one sweep: start, then n words; gaps=1 adds an idle cycle with a stray start and mode flip
    task automatic sweep(input int m, input int f[8], input int v[8], input int n, input int gaps);
        mode_tx = m[0]; start = 1'b1;
        tick();
        start = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (gaps != 0) begin
                res_valid = 0; start = 1'b1; mode_tx = ~m[0];
                tick();
                start = 1'b0; mode_tx = m[0];
            end
            res_valid = 1'b1; res_word = mk(f[i], v[i]);
            tick();
        end
        res_valid = 1'b0;
        tick();
    endtask

    initial begin
        #(200000 * 5);
        nfail++;
        $display("FAIL watchdog R8 act=hung exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        int ok[8]   = '{1,1,1,1,1,1,1,1};
        int rxa[8]  = '{3,7,10,5,12,9,4,8};
        int txa[8]  = '{20,15,30,18,40,22,17,25};
        int rxnw[8] = '{4,6,8,31,5,5,5,5};
        int rxe[8]  = '{2,3,4,5,6,7,8,9};
        int rxe8[8] = '{2,3,4,5,6,7,8,31};
        int rxs[8]  = '{31,3,31,1,0,2,6,7};
        int f5[8]   = '{1,1,1,1,1,0,1,1};
        int f0[8]   = '{0,1,1,1,1,1,1,1};
        int f6[8]   = '{1,1,1,1,1,1,0,1};
        int txnw[8] = '{9,12,0,5,5,5,5,5};
        int txs[8]  = '{0,9,12,30,5,7,63,1};

        cur_tag = "R1";
        do_reset();
        chk("R1 reset state", int'(lane_state), 3);
        chk("R1 reset lock", int'(lane_lock), 1);

        cur_tag = "R2 R3 R5 rx primary";
        sweep(0, ok, rxa, 8, 0);
        chk("R5 rx shift is max tap", int'(shift_val), 13);

        cur_tag = "R2 R5 R8 tx primary with gaps";
        do_reset();
        sweep(1, ok, txa, 8, 1);
        chk("R5 tx shift is min tap", int'(shift_val), 14);

        cur_tag = "R4 R10 rx no window";
        do_reset();
        sweep(0, ok, rxnw, 4, 0);
        chk("R4 to extended", int'(lane_state), 4);
        cur_tag = "R8 word while not ready";
        res_valid = 1'b1; res_word = mk(0, 0);
        tick(); tick();
        res_valid = 1'b0;
        chk("R8 stray word ignored", int'(lane_state), 4);

        cur_tag = "R6 extended pass";
        sweep(0, ok, rxe, 8, 0);
        chk("R6 extended lock", int'(lane_lock), 1);

        cur_tag = "R6 R8 no window on last word";
        sweep(0, ok, rxe8, 8, 0);
        chk("R6 to shifted", int'(lane_state), 2);
        res_valid = 1'b1; res_word = mk(1, 3);
        tick();
        res_valid = 1'b0;

        cur_tag = "R7 R3 shifted rx all flags";
        sweep(0, ok, rxs, 8, 0);
        chk("R7 shifted lock", int'(lane_lock), 1);
        chk("R3 rx tap 32", int'(shift_val), 32);

        cur_tag = "R7 shifted flag fail";
        sweep(0, f5, rxs, 6, 0);
        chk("R7 to fail", int'(lane_state), 1);

        cur_tag = "R9 start in fail";
        sweep(0, ok, rxs, 0, 0);
        sweep(1, ok, rxs, 0, 0);
        chk("R9 stays fail", int'(lane_state), 1);

        cur_tag = "R4 tx flag fail";
        do_reset();
        sweep(1, f0, txa, 1, 0);
        chk("R4 to fail", int'(lane_state), 1);

        cur_tag = "R4 R6 tx ladder";
        do_reset();
        sweep(1, ok, txnw, 3, 0);
        sweep(1, f6, txa, 7, 0);
        chk("R6 tx to shifted", int'(lane_state), 2);

        cur_tag = "R3 R7 tx shifted saturate";
        sweep(1, ok, txs, 8, 0);
        chk("R3 tx tap saturates", int'(shift_val), 0);
        chk("R7 tx shifted lock", int'(lane_lock), 1);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule